// File: doc/BRIEF.md
# Clock Stop Gating

This block sits between a set of already-synthesized source clocks and their output pins. Each source clock passes through its own glitch-free gate, so a clock that is halted always ends low after a full-width high phase. When it is released, it resumes with a full-width high phase. There are two groups that can be halted from the board. The processor pair halts on a processor stop pin. The peripheral bus clocks halt on a peripheral stop pin, except for one free-running peripheral clock. The chipset processor pair is never affected by either pin.

The stop pins are honoured only if a mode strap was low while reset was asserted. The strap is sampled during reset and then held, so later changes on it do nothing. Every output also has an enable bit from the register file. Clearing that bit forces its output low at once, without waiting for a clock edge. A power-down input overrides the processor pair. In one processor mode, a control bit chooses between driving a fixed true-high, complement-low level and releasing both pins. In the other processor mode, both pins are held low.

Channel layout is fixed: channel 0 is the processor true clock, channel 1 the processor complement clock, channels 2 and 3 the chipset processor pair, channel 4 the free-running peripheral clock, and channels 5 upward the stoppable peripheral clocks (NPCI of them).

Top module: `clk_stop_gate`

## Requirements
- R1: With stop pins enabled, driving `cpu_stop_n` low halts channels 0 and 1 low within three periods of their own source clocks.
- R2: `cpu_stop_n` has no effect on channels 2 and 3 or on any peripheral channel.
- R3: With stop pins enabled, driving `pci_stop_n` low halts channels 5 and up low, while channel 4 and the processor channels keep toggling.
- R4: `stop_strap` is captured on `ref_clk` while `rst` is high. If it was captured high, both stop pins are ignored, including after `stop_strap` later changes with no new reset.
- R5: A `reg_en` bit at 0 forces its channel output low immediately, even in the middle of a high phase. A bit at 1 lets the channel run.
- R6: Halting and releasing through the stop pins never produce a high pulse shorter than the source clock's high phase.
- R7: Releasing a stop pin restarts the halted channels.
- R8: With `pd_n` low and `p4_mode` high: if `pd_float` is 0, channel 0 is high, channel 1 is low and `cpu_oe` is 1. If `pd_float` is 1, `cpu_oe` is 0.
- R9: With `pd_n` low and `p4_mode` low, channels 0 and 1 are low and `cpu_oe` is 1 whatever `pd_float` is.
- R10: After reset with the stop pins high, every enabled channel toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running clock used to sample the strap |
| rst | input | 1 | Synchronous active-high reset, held over several edges of every source clock |
| stop_strap | input | 1 | Mode strap; low during reset enables the stop pins |
| src_clk | input | 5+NPCI | Source clocks, one per channel |
| cpu_stop_n | input | 1 | Active-low processor stop request |
| pci_stop_n | input | 1 | Active-low peripheral stop request |
| reg_en | input | 5+NPCI | Per-channel register enables, 1 = run |
| p4_mode | input | 1 | Processor mode select for power-down behaviour |
| pd_n | input | 1 | Active-low power-down |
| pd_float | input | 1 | Power-down choice in processor mode 1: 0 = drive levels, 1 = release |
| clk_out | output | 5+NPCI | Gated clock outputs |
| cpu_oe | output | 1 | Output enable for the processor pair (0 = high impedance) |

## Verification
The stop pins are exercised one group at a time. After each stimulus, the channels that should halt and the channels that should keep running are both measured. This separates a stop that reaches the wrong group from one that reaches no group at all. The same stop is applied twice, once with the strap captured high and once with it captured low. The high case, followed by a strap change with no reset, shows whether the strap is truly held rather than sampled live. The width of every high pulse is measured across the halt and release phases to catch shortened pulses. A register enable is cleared in the middle of a high phase to show that the override acts without waiting for a clock edge. Power-down is run through all four combinations of processor mode and float bit.

// File: rtl/clk_stop_gate_pkg.sv
`timescale 1ns/1ps
package clk_stop_gate_pkg;

    typedef enum logic [1:0] {
        CH_CPU  = 2'd0,
        CH_CS   = 2'd1,
        CH_FREE = 2'd2,
        CH_PCI  = 2'd3
    } chan_kind_e;

    localparam int N_FIXED = 5;

    function automatic chan_kind_e chan_kind(input int idx);
        if (idx < 2)      return CH_CPU;
        else if (idx < 4) return CH_CS;
        else if (idx < 5) return CH_FREE;
        else              return CH_PCI;
    endfunction

endpackage

// File: rtl/clkgate_sync.sv
`timescale 1ns/1ps
module clkgate_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run_async,
    output logic run_sync
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= {pipe[STAGES-2:0], run_async};
    end

    assign run_sync = pipe[STAGES-1];
endmodule

// File: rtl/clkgate_cell.sv
`timescale 1ns/1ps
module clkgate_cell (
    input  logic clk,
    input  logic en,
    input  logic force_en,
    output logic gclk
);
    logic en_l;

    // transparent while the clock is low: enable changes land only between pulses
    always_latch begin
        if (!clk) en_l = en;
    end

    assign gclk = clk & en_l & force_en;
endmodule

// File: rtl/clkgate_chan.sv
`timescale 1ns/1ps
module clkgate_chan #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic stop_req,
    input  logic reg_en,
    output logic gclk
);
    logic run_s;

    clkgate_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .run_async (~stop_req),
        .run_sync  (run_s)
    );

    clkgate_cell u_cell (
        .clk      (clk),
        .en       (run_s),
        .force_en (reg_en),
        .gclk     (gclk)
    );
endmodule

// File: rtl/clk_stop_gate.sv
`timescale 1ns/1ps
module clk_stop_gate
    import clk_stop_gate_pkg::*;
#(
    parameter int NPCI        = 3,
    parameter int SYNC_STAGES = 2,
    localparam int NCH        = N_FIXED + NPCI
) (
    input  logic           ref_clk,
    input  logic           rst,
    input  logic           stop_strap,
    input  logic [NCH-1:0] src_clk,
    input  logic           cpu_stop_n,
    input  logic           pci_stop_n,
    input  logic [NCH-1:0] reg_en,
    input  logic           p4_mode,
    input  logic           pd_n,
    input  logic           pd_float,
    output logic [NCH-1:0] clk_out,
    output logic           cpu_oe
);
    logic           strap_q;
    logic           cpu_req;
    logic           pci_req;
    logic [NCH-1:0] gated;
    logic           pd;

    // strap captured only while reset is held
    always_ff @(posedge ref_clk) begin
        if (rst) strap_q <= stop_strap;
    end

    assign cpu_req = ~cpu_stop_n & ~strap_q;
    assign pci_req = ~pci_stop_n & ~strap_q;
    assign pd      = ~pd_n;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam chan_kind_e KIND = chan_kind(i);
        logic stop_i;

        if (KIND == CH_CPU) begin : g_cpu
            assign stop_i = cpu_req;
        end else if (KIND == CH_PCI) begin : g_pci
            assign stop_i = pci_req;
        end else begin : g_free
            assign stop_i = 1'b0;
        end

        clkgate_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
            .clk      (src_clk[i]),
            .rst      (rst),
            .stop_req (stop_i),
            .reg_en   (reg_en[i]),
            .gclk     (gated[i])
        );
    end

    always_comb begin
        clk_out = gated;
        cpu_oe  = 1'b1;
        if (pd) begin
            clk_out[0] = p4_mode & ~pd_float;
            clk_out[1] = 1'b0;
            cpu_oe     = ~(p4_mode & pd_float);
        end
    end
endmodule

// File: rtl/clk_stop_gate_chk.sv
`timescale 1ns/1ps
module clk_stop_gate_chk
    import clk_stop_gate_pkg::*;
#(
    parameter int NPCI = 3,
    localparam int NCH = N_FIXED + NPCI
) (
    input logic           ref_clk,
    input logic           rst,
    input logic           strap_q,
    input logic [NCH-1:0] reg_en,
    input logic           p4_mode,
    input logic           pd_n,
    input logic           pd_float,
    input logic [NCH-1:0] clk_out,
    input logic           cpu_oe
);
    logic [NCH-1:0] pd_mask;
    always_comb begin
        pd_mask = '1;
        if (!pd_n) pd_mask[1:0] = 2'b00;
    end

    p_regen_low_r5: assert property (@(posedge ref_clk) disable iff (rst)
        ((~reg_en) & clk_out & pd_mask) == '0);

    p_pd_drive_r8: assert property (@(posedge ref_clk) disable iff (rst)
        (!pd_n && p4_mode && !pd_float) |-> (clk_out[0] && !clk_out[1] && cpu_oe));

    p_pd_float_r8: assert property (@(posedge ref_clk) disable iff (rst)
        (!pd_n && p4_mode && pd_float) |-> !cpu_oe);

    p_pd_k7_r9: assert property (@(posedge ref_clk) disable iff (rst)
        (!pd_n && !p4_mode) |-> (!clk_out[0] && !clk_out[1] && cpu_oe));

    p_strap_hold_r4: assert property (@(posedge ref_clk) disable iff (rst)
        1'b1 |=> $stable(strap_q));
endmodule

bind clk_stop_gate clk_stop_gate_chk #(.NPCI(NPCI)) u_chk (.*);

// File: tb/clk_stop_gate_bench.sv
`timescale 1ns/1ps
module clk_stop_gate_bench;
    localparam int NPCI = 3;
    localparam int NCH  = 5 + NPCI;

    logic           clk = 1'b0;
    logic           pci_clk = 1'b0;
    logic           rst;
    logic           stop_strap;
    logic [NCH-1:0] src_clk;
    logic           cpu_stop_n, pci_stop_n;
    logic [NCH-1:0] reg_en;
    logic           p4_mode, pd_n, pd_float;
    logic [NCH-1:0] clk_out;
    logic           cpu_oe;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;
    always @(posedge clk) pci_clk <= ~pci_clk;

    assign src_clk[0] = clk;
    assign src_clk[1] = ~clk;
    assign src_clk[2] = clk;
    assign src_clk[3] = ~clk;
    for (genvar k = 4; k < NCH; k++) begin : g_src
        assign src_clk[k] = pci_clk;
    end

    clk_stop_gate #(.NPCI(NPCI)) u_clk_stop_gate (
        .ref_clk    (clk),
        .rst        (rst),
        .stop_strap (stop_strap),
        .src_clk    (src_clk),
        .cpu_stop_n (cpu_stop_n),
        .pci_stop_n (pci_stop_n),
        .reg_en     (reg_en),
        .p4_mode    (p4_mode),
        .pd_n       (pd_n),
        .pd_float   (pd_float),
        .clk_out    (clk_out),
        .cpu_oe     (cpu_oe)
    );

    // edge counting and pulse width monitor
    int      edge_cnt [NCH];
    realtime rise_t   [NCH];
    bit      runt_on = 1'b0;
    int      runt_errs = 0;

    for (genvar g = 0; g < NCH; g++) begin : g_mon
        initial begin edge_cnt[g] = 0; rise_t[g] = 0; end
        always @(posedge clk_out[g]) begin
            edge_cnt[g] = edge_cnt[g] + 1;
            rise_t[g]   = $realtime;
        end
        always @(negedge clk_out[g]) begin
            if (runt_on) begin
                if (($realtime - rise_t[g]) < ((g < 4) ? 3.9 : 7.9)) begin
                    runt_errs = runt_errs + 1;
                    $display("FAIL R6 ch%0d high for %0t, expected full phase", g,
                             $realtime - rise_t[g]);
                end
            end
        end
    end

    // scoreboard
    typedef struct {
        string tag;
        int    ch;
        bit    run;
    } exp_t;
    exp_t exp_q[$];
    event start_ev, done_ev;

    initial begin
        forever begin
            int snap [NCH];
            @(start_ev);
            for (int i = 0; i < NCH; i++) snap[i] = edge_cnt[i];
            #64;
            while (exp_q.size() > 0) begin
                exp_t it;
                int   d;
                bit   ok;
                it = exp_q.pop_front();
                d  = edge_cnt[it.ch] - snap[it.ch];
                ok = it.run ? (d >= 3) : (d == 0 && clk_out[it.ch] == 1'b0);
                checks++;
                if (!ok) begin
                    errors++;
                    $display("FAIL %s ch%0d: edges=%0d level=%0b, expected %s",
                             it.tag, it.ch, d, clk_out[it.ch],
                             it.run ? "running" : "stopped low");
                end
            end
            ->done_ev;
        end
    end

    task automatic expect_ch(input string tag, input int ch, input bit run);
        exp_t it;
        it.tag = tag; it.ch = ch; it.run = run;
        exp_q.push_back(it);
    endtask

    task automatic settle_and_check();
        #80;
        ->start_ev;
        @(done_ev);
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b, expected %0b", tag, act, exp);
        end
    endtask

    task automatic at_drive();
        @(negedge clk);
        #1;
    endtask

    task automatic do_reset(input logic strap);
        at_drive();
        rst = 1'b1;
        stop_strap = strap;
        repeat (6) @(posedge pci_clk);
        at_drive();
        rst = 1'b0;
    endtask

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; stop_strap = 1'b1;
        cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
        reg_en = '1; p4_mode = 1'b1; pd_n = 1'b1; pd_float = 1'b0;

        // R10: all channels run after reset
        do_reset(1'b1);
        for (int i = 0; i < NCH; i++) expect_ch("R10 after reset", i, 1'b1);
        settle_and_check();

        // R4: strap captured high -> stop pins ignored, even after strap change
        at_drive(); cpu_stop_n = 1'b0; pci_stop_n = 1'b0;
        expect_ch("R4 strap high cpu", 0, 1'b1);
        expect_ch("R4 strap high pci", 5, 1'b1);
        settle_and_check();
        at_drive(); stop_strap = 1'b0;
        expect_ch("R4 strap changed w/o reset cpu", 1, 1'b1);
        expect_ch("R4 strap changed w/o reset pci", 7, 1'b1);
        settle_and_check();
        at_drive(); cpu_stop_n = 1'b1; pci_stop_n = 1'b1;

        // enable stop pins
        do_reset(1'b0);
        runt_on = 1'b1;

        // R1 / R2
        at_drive(); cpu_stop_n = 1'b0;
        expect_ch("R1 cpu true", 0, 1'b0);
        expect_ch("R1 cpu comp", 1, 1'b0);
        expect_ch("R2 chipset t", 2, 1'b1);
        expect_ch("R2 chipset c", 3, 1'b1);
        expect_ch("R2 pci", 6, 1'b1);
        settle_and_check();

        // R7 cpu release
        at_drive(); cpu_stop_n = 1'b1;
        expect_ch("R7 cpu true", 0, 1'b1);
        expect_ch("R7 cpu comp", 1, 1'b1);
        settle_and_check();

        // R3
        at_drive(); pci_stop_n = 1'b0;
        for (int i = 5; i < NCH; i++) expect_ch("R3 pci stopped", i, 1'b0);
        expect_ch("R3 free pci", 4, 1'b1);
        expect_ch("R3 cpu runs", 0, 1'b1);
        settle_and_check();

        // R7 pci release
        at_drive(); pci_stop_n = 1'b1;
        for (int i = 5; i < NCH; i++) expect_ch("R7 pci", i, 1'b1);
        settle_and_check();

        runt_on = 1'b0;
        checks++;
        if (runt_errs != 0) begin
            errors++;
            $display("FAIL R6 short pulses: got %0d, expected 0", runt_errs);
        end

        // R5: asynchronous disable in the middle of a high phase
        @(posedge clk); #1;
        reg_en[2] = 1'b0;
        #0.5;
        check_bit("R5 async low ch2", clk_out[2], 1'b0);
        at_drive(); reg_en[5] = 1'b0;
        expect_ch("R5 disabled ch2", 2, 1'b0);
        expect_ch("R5 disabled ch5", 5, 1'b0);
        expect_ch("R5 other runs", 3, 1'b1);
        settle_and_check();
        at_drive(); reg_en = '1;
        expect_ch("R5 enabled ch2", 2, 1'b1);
        expect_ch("R5 enabled ch5", 5, 1'b1);
        settle_and_check();

        // R8
        at_drive(); pd_n = 1'b0; p4_mode = 1'b1; pd_float = 1'b0;
        #2;
        check_bit("R8 drive true", clk_out[0], 1'b1);
        check_bit("R8 drive comp", clk_out[1], 1'b0);
        check_bit("R8 drive oe", cpu_oe, 1'b1);
        at_drive(); pd_float = 1'b1;
        #2;
        check_bit("R8 float oe", cpu_oe, 1'b0);

        // R9
        at_drive(); p4_mode = 1'b0;
        #2;
        check_bit("R9 true low f1", clk_out[0], 1'b0);
        check_bit("R9 comp low f1", clk_out[1], 1'b0);
        check_bit("R9 oe f1", cpu_oe, 1'b1);
        at_drive(); pd_float = 1'b0;
        #2;
        check_bit("R9 true low f0", clk_out[0], 1'b0);
        check_bit("R9 oe f0", cpu_oe, 1'b1);

        at_drive(); pd_n = 1'b1; p4_mode = 1'b1;
        expect_ch("R10 resume ch0", 0, 1'b1);
        expect_ch("R10 resume ch1", 1, 1'b1);
        settle_and_check();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule